// File: doc/BRIEF.md
# Dual-Mode 8-Bit Timer Counter

An 8-bit up-counter paired with a compare register. Every time the counter reaches the compare value it returns to zero and emits a one-cycle interrupt pulse. The counter has two sources, chosen by a mode input:

- **Event mode** counts qualified falling edges on an external pin.
- **Divider mode** counts enable ticks from an internal power-of-two prescaler. Each match also inverts a toggle flip-flop, so the output pin, which carries the inverse of that flip-flop, becomes a square wave with a 50% duty cycle.

Software starts and stops the timer with a level input. It can write the compare value at any time. It can preset the toggle flip-flop only while the timer is stopped.

The external pin passes through two synchroniser flops. It is then sampled once per machine cycle, which lasts 2^MC_LOG2 system clocks (4 by default). A falling edge is accepted only after two sampled highs are followed by two sampled lows.

Top module: `dual_mode_timer8`

## Requirements
- R1: After reset, irq_o is 0 and div_out_o is 1 (the toggle flip-flop is 0).
- R2: In divider mode (mode_i=1), a tick occurs every 2^(div_sel_i+1) clocks, counted from the clock edge that first samples run_i high. With compare value C, irq_o pulses after every C ticks, and a compare value of 0 means 256 ticks. The counter restarts from 0 after each match.
- R3: In divider mode, each match inverts the toggle flip-flop and div_out_o always equals its inverse. The result is a square wave whose half period is C·2^(div_sel_i+1) clocks.
- R4: In event mode (mode_i=0), irq_o pulses once for every C qualified falling edges of ev_pin_i, and div_out_o does not change on matches.
- R5: A falling edge is qualified only when the four most recent machine-cycle samples read high, high, low, low (oldest first). A low shorter than one machine cycle is never counted.
- R6: A compare write (cmp_we_i) takes effect from the next clock, with no buffering, including while the timer runs.
- R7: While run_i is low, nothing advances, irq_o stays 0 and div_out_o holds its level. When run_i rises, the counter and the prescaler both restart from 0.
- R8: A flip-flop preset (ff_we_i) loads ff_data_i only if run_i is low in that cycle and was low in the previous cycle. A write while running, or in the same cycle that the timer stops, is ignored.
- R9: In event mode, a flip-flop preset always loads 0, whatever the value of ff_data_i.
- R10: irq_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Level: 1 runs the timer, 0 stops it |
| mode_i | input | 1 | 0 selects event mode, 1 selects divider mode |
| div_sel_i | input | SEL_W | Prescaler select, divide by 2^(value+1) |
| cmp_we_i | input | 1 | Write strobe for the compare register |
| cmp_data_i | input | CNT_W | Compare value |
| ff_we_i | input | 1 | Preset strobe for the toggle flip-flop |
| ff_data_i | input | 1 | Preset value |
| ev_pin_i | input | 1 | External event input (asynchronous) |
| div_out_o | output | 1 | Inverse of the toggle flip-flop |
| irq_o | output | 1 | One-cycle match pulse |

## Verification
Divider mode is swept over every prescaler setting and several compare values, including 0, which stands for 256. At each clock the bench predicts the interrupt and the output level from the arithmetic. Because each run ends at an arbitrary count and is then restarted, the sweep shows whether start clears both the counter and the prescaler.

A compare write in the middle of a count distinguishes an immediate update from a buffered one. Preset writes made while running, in the cycle the timer stops, and in event mode distinguish the three guard conditions.

Event mode is driven with clean wide pulses and with narrow low glitches. The wide pulses check the match count. The glitches show whether the two-sample qualification rejects them, and a following pair of clean edges confirms that the count was kept intact.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    typedef enum logic {
        MODE_EVENT  = 1'b0,
        MODE_DIVIDE = 1'b1
    } dmt_mode_e;
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int SEL_W   = 2,
    parameter int MC_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             div_tick_o,
    output logic             mc_tick_o
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int PRE_W = (NSEL > MC_LOG2) ? NSEL : MC_LOG2;

    typedef struct packed {
        logic [PRE_W-1:0] pc;
    } pre_s;

    pre_s pre_d, pre_q;
    logic [NSEL-1:0] tick_vec;

    always_comb begin
        pre_d    = pre_q;
        pre_d.pc = run_i ? pre_q.pc + PRE_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_tick
        assign tick_vec[i] = run_i && (&pre_q.pc[i:0]);
    end

    assign div_tick_o = tick_vec[sel_i];
    assign mc_tick_o  = run_i && (&pre_q.pc[MC_LOG2-1:0]);

    // R7
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pre_q.pc == '0));
endmodule

// File: rtl/dmt_event_sync.sv
module dmt_event_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sample_i,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic       s1;
        logic       s2;
        logic [2:0] hist;
    } sync_s;

    sync_s sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_i;
        sy_d.s2 = sy_q.s1;
        if (!run_i)        sy_d.hist = '0;
        else if (sample_i) sy_d.hist = {sy_q.hist[1:0], sy_q.s2};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign fall_o = run_i && sample_i && ({sy_q.hist, sy_q.s2} == 4'b1100);

    // R5
    ev_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> (sy_q.hist == 3'b100));
endmodule

// File: rtl/dual_mode_timer8.sv
module dual_mode_timer8
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SEL_W   = 2,
    parameter int MC_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             mode_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_data_i,
    input  logic             ff_we_i,
    input  logic             ff_data_i,
    input  logic             ev_pin_i,
    output logic             div_out_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             ff;
        logic             run;
        logic             irq;
    } tmr_s;

    tmr_s      st_d, st_q;
    dmt_mode_e mode;
    logic      div_tick, mc_tick, ev_fall;
    logic      step, hit, ff_load;

    assign mode = dmt_mode_e'(mode_i);

    dmt_prescaler #(.SEL_W(SEL_W), .MC_LOG2(MC_LOG2)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.run),
        .sel_i      (div_sel_i),
        .div_tick_o (div_tick),
        .mc_tick_o  (mc_tick)
    );

    dmt_event_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run),
        .sample_i (mc_tick),
        .pin_i    (ev_pin_i),
        .fall_o   (ev_fall)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.run = run_i;
        step     = (mode == MODE_DIVIDE) ? div_tick : ev_fall;
        hit      = (CNT_W'(st_q.cnt + 1'b1) == st_q.cmp);
        ff_load  = ff_we_i && !run_i && !st_q.run;

        if (cmp_we_i) st_d.cmp = cmp_data_i;

        if (run_i && !st_q.run) begin
            st_d.cnt = '0;
        end else if (st_q.run && step) begin
            if (hit) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
                if (mode == MODE_DIVIDE) st_d.ff = ~st_q.ff;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (ff_load) st_d.ff = (mode == MODE_DIVIDE) ? ff_data_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_out_o = ~st_q.ff;
    assign irq_o     = st_q.irq;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |=> !st_q.irq);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !(ff_we_i && !run_i)) |=> $stable(div_out_o));

    // R3
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && $past(mode_i) == MODE_DIVIDE) |-> (st_q.ff != $past(st_q.ff)));

    // R4
    ev_no_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && $past(mode_i) == MODE_EVENT) |-> $stable(st_q.ff));

    // R8
    ff_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ff) |-> (st_q.irq ||
            ($past(ff_we_i) && !$past(run_i) && !$past(st_q.run))));

    // R9
    ev_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_we_i && !run_i && !st_q.run && mode_i == MODE_EVENT) |=> !st_q.ff);
endmodule

// File: tb/dual_mode_timer8_bench.sv
module dual_mode_timer8_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run, mode, cmp_we, ff_we, ff_data, ev_pin;
    logic [1:0] div_sel;
    logic [7:0] cmp_data;
    logic       div_out, irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  irq_seen = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mode_timer8 u_dual_mode_timer8 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .mode_i     (mode),
        .div_sel_i  (div_sel),
        .cmp_we_i   (cmp_we),
        .cmp_data_i (cmp_data),
        .ff_we_i    (ff_we),
        .ff_data_i  (ff_data),
        .ev_pin_i   (ev_pin),
        .div_out_o  (div_out),
        .irq_o      (irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // divider sweep run: R2, R3, R7, R8
    task automatic run_div(input int sel, input int c, input bit ff0);
        int  cr;
        int  n;
        int  held;
        cr = ((c == 0) ? 256 : c) * (2 << sel);
        n  = 2 * cr + 1;
        @(negedge clk);
        run = 0; mode = 1; div_sel = sel[1:0];
        cmp_we = 1; cmp_data = c[7:0]; ff_we = 1; ff_data = ff0;
        @(negedge clk);
        cmp_we = 0; ff_we = 0;
        chk("R8 preset while stopped", div_out, !ff0);
        run = 1;
        @(negedge clk);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            chk("R2 divider irq", irq, (k % cr == 0) ? 1 : 0);
            chk("R3 divider output", div_out, !(ff0 ^ ((k / cr) & 1)));
            if (k == n) run = 0;
        end
        held = div_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R7 stopped irq", irq, 0);
            chk("R7 stopped hold", div_out, held);
        end
    endtask

    task automatic ev_fall_pulse(input int low_len, input int high_len);
        ev_pin = 0;
        repeat (low_len) @(negedge clk);
        ev_pin = 1;
        repeat (high_len) @(negedge clk);
    endtask

    initial begin
        int cvals[4];
        int base;
        int out_low;
        cvals = '{1, 2, 3, 7};
        rst_n = 0; run = 0; mode = 0; div_sel = 0; cmp_we = 0; cmp_data = 0;
        ff_we = 0; ff_data = 0; ev_pin = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset output", div_out, 1);

        for (int s = 0; s < 4; s++)
            for (int ci = 0; ci < 4; ci++)
                run_div(s, cvals[ci], 1'((s + ci) % 2));
        run_div(0, 0, 1'b1);

        // R6: compare rewritten mid-count
        @(negedge clk);
        mode = 1; div_sel = 0; cmp_we = 1; cmp_data = 8'd10; ff_we = 1; ff_data = 0;
        @(negedge clk);
        cmp_we = 0; ff_we = 0; run = 1;
        @(negedge clk);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk("R6 immediate compare", irq, (k == 8 || k == 16) ? 1 : 0);
            if (k == 6) begin cmp_we = 1; cmp_data = 8'd4; end
            if (k == 7) cmp_we = 0;
        end
        run = 0;
        repeat (3) @(negedge clk);

        // R8: preset ignored while running and at the stop cycle
        mode = 1; div_sel = 0; cmp_we = 1; cmp_data = 8'd50; ff_we = 1; ff_data = 0;
        @(negedge clk);
        cmp_we = 0; ff_we = 0; run = 1;
        @(negedge clk);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk("R8 running preset ignored", div_out, 1);
            if (k == 3) begin ff_we = 1; ff_data = 1; end
            if (k == 4) ff_we = 0;
        end
        run = 0; ff_we = 1; ff_data = 1;
        @(negedge clk);
        chk("R8 stop-cycle preset ignored", div_out, 1);
        @(negedge clk);
        ff_we = 0;
        chk("R8 stopped preset applied", div_out, 0);

        // R9: event-mode preset forces 0
        mode = 0; ff_we = 1; ff_data = 1;
        @(negedge clk);
        ff_we = 0;
        chk("R9 event preset", div_out, 1);

        // R4: event counting with clean pulses
        cmp_we = 1; cmp_data = 8'd3;
        @(negedge clk);
        cmp_we = 0; ev_pin = 1; run = 1;
        repeat (20) @(negedge clk);
        base = irq_seen;
        out_low = 0;
        for (int e = 0; e < 10; e++) begin
            ev_fall_pulse(16, 16);
            if (div_out == 0) out_low++;
        end
        repeat (20) @(negedge clk);
        chk("R4 event irq count", irq_seen - base, 3);
        chk("R4 event output unchanged", out_low, 0);

        // R5: narrow lows rejected, count preserved
        base = irq_seen;
        for (int e = 0; e < 6; e++) ev_fall_pulse(3, 16);
        chk("R5 glitches rejected", irq_seen - base, 0);
        ev_fall_pulse(16, 16);
        ev_fall_pulse(16, 16);
        repeat (20) @(negedge clk);
        chk("R5 count kept after glitches", irq_seen - base, 1);

        // R7: stopped timer ignores events
        run = 0;
        repeat (3) @(negedge clk);
        base = irq_seen;
        for (int e = 0; e < 4; e++) ev_fall_pulse(16, 16);
        chk("R7 stopped event ignored", irq_seen - base, 0);
        chk("R7 stopped output", div_out, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1-all actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule